// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register for serialising a byte. While the active-low load control is held low, a system clock edge copies a parallel byte into all stages at once. When the load control is high, each enabled clock edge moves the data one stage toward the last stage. On those edges the serial input enters the first stage.

A clock-inhibit input gates the shifting. Real gating of the clock net is not used. The inhibit input acts as a clock enable on the single system clock, so an edge with inhibit high leaves the register unchanged unless a load is requested. The last stage is driven out in true form and in complemented form. A byte loaded here appears most-significant bit first at the output.

Top module: `piso_shifter`

## Requirements
- R1: While `rstN` is low, all stages clear to zero, so `lastBit` reads 0 and `lastBitN` reads 1.
- R2: On a clock edge with `shiftLoadN` low, every stage takes its parallel input. `parIn[0]` feeds the first stage and `parIn[7]` feeds the last stage, so `lastBit` equals `parIn[7]` after that edge.
- R3: A load takes priority over inhibit: with `shiftLoadN` low, the byte is captured even while `inhibit` is high.
- R4: On a clock edge with `shiftLoadN` high and `inhibit` low, the first stage takes `serIn` and every other stage takes the value of the stage before it.
- R5: On a clock edge with `shiftLoadN` high and `inhibit` high, all stages keep their values.
- R6: `lastBitN` is at all times the logical complement of `lastBit`.
- R7: After loading byte P, eight shift edges with `serIn` held at S present P[6], P[5], down to P[0] on `lastBit`, one bit per edge, followed by S.
- R8: While `shiftLoadN` is high, `parIn` has no effect on any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| shiftLoadN | input | 1 | Low: parallel load; high: shift or hold |
| inhibit | input | 1 | High blocks shifting (clock-enable form of the NOR gate) |
| serIn | input | 1 | Serial data into the first stage |
| parIn | input | 8 | Parallel byte; bit 0 to first stage, bit 7 to last stage |
| lastBit | output | 1 | Last stage, true form |
| lastBitN | output | 1 | Last stage, complemented |

## Verification
Only the last stage reaches the ports. A corrupted inner stage therefore stays hidden until enough shift edges have moved it out: a fault in stage k shows up to seven edges later. For this reason the bench follows every load with a full run of shifts and compares the output on every cycle, so that the content of each stage is read out. A wrong load or a wrong hold decision on the last stage shows up one cycle after the edge. A polarity fault on the complement output shows up at once.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } stageStrobe_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         shiftLoadN,
  input  logic         inhibit,
  output stageStrobe_t strobe
);
  always_comb begin
    strobe.load  = ~shiftLoadN;
    strobe.shift = shiftLoadN & ~inhibit;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftLoadN && inhibit) |-> (strobe.load && !strobe.shift)); // R3
  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (shiftLoadN && inhibit) |-> !(strobe.load || strobe.shift)); // R5
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobe_t     strobe,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             lastBit
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] shiftSrc;

  assign shiftSrc[0] = serIn;
  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign shiftSrc[i] = stages[i-1];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             stages[i] <= 1'b0;
      else if (strobe.load)  stages[i] <= parIn[i];
      else if (strobe.shift) stages[i] <= shiftSrc[i];
    end
  end

  assign lastBit = stages[LAST];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (stages == $past(parIn))); // R2
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && strobe.shift) |=>
      (stages == {$past(stages[LAST-1:0]), $past(serIn)})); // R4
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> $stable(stages)); // R8
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftLoadN,
  input  logic             inhibit,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             lastBit,
  output logic             lastBitN
);
  stageStrobe_t strobe;

  piso_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .shiftLoadN (shiftLoadN),
    .inhibit    (inhibit),
    .strobe     (strobe)
  );

  piso_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .serIn   (serIn),
    .parIn   (parIn),
    .lastBit (lastBit)
  );

  assign lastBitN = ~lastBit;

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    lastBitN != lastBit); // R6
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |-> (!lastBit && lastBitN)); // R1
endmodule

// File: tb/test_piso_shifter.sv
module test_piso_shifter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       shiftLoadN = 1'b1;
  logic       inhibit = 1'b1;
  logic       serIn = 1'b0;
  logic [7:0] parIn = 8'h00;
  logic       lastBit, lastBitN;

  int checks = 0;
  int fails = 0;
  bit model[$];   // front = last stage, back = first stage
  bit done = 0;

  always #4 clk = ~clk;

  piso_shifter i_piso_shifter (
    .clk(clk), .rstN(rstN), .shiftLoadN(shiftLoadN), .inhibit(inhibit),
    .serIn(serIn), .parIn(parIn), .lastBit(lastBit), .lastBitN(lastBitN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(input string req);
    check(req, lastBit, model[0]);
    check("R6", lastBitN, ~model[0]);
  endtask

  task automatic step(input logic ld, input logic inh, input logic s,
                      input logic [7:0] p, input string req);
    @(negedge clk);
    shiftLoadN = ld; inhibit = inh; serIn = s; parIn = p;
    @(posedge clk);
    if (!ld) begin
      model.delete();
      for (int i = 7; i >= 0; i--) model.push_back(p[i]);
    end else if (!inh) begin
      void'(model.pop_front());
      model.push_back(s);
    end
    #2;
    checkOut(req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model.push_back(1'b0);
    #10;
    checkOut("R1");
    @(negedge clk);
    rstN = 1'b1;
    // load then shift out with serIn high
    step(1'b0, 1'b0, 1'b0, 8'hB4, "R2");
    for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 1'b1, 8'h00, "R7");
    // load under inhibit
    step(1'b0, 1'b1, 1'b0, 8'h5A, "R3");
    // hold with changing parallel bits
    step(1'b1, 1'b1, 1'b1, 8'hFF, "R5");
    step(1'b1, 1'b1, 1'b0, 8'hA5, "R8");
    step(1'b1, 1'b1, 1'b1, 8'h3C, "R8");
    // shift out held contents, proving parIn was ignored
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, k[0], 8'hC3, "R4");
    // inhibit mid-stream, then continue
    step(1'b0, 1'b0, 1'b0, 8'h81, "R2");
    step(1'b1, 1'b0, 1'b0, 8'h00, "R4");
    step(1'b1, 1'b1, 1'b1, 8'hFF, "R5");
    for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b1, 8'h00, "R7");
    // reset mid-stream
    @(negedge clk);
    rstN = 1'b0;
    #1;
    model.delete();
    for (int i = 0; i < 8; i++) model.push_back(1'b0);
    checkOut("R1");
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule